// File: doc/BRIEF.md
# Supply and Watchdog Reset Generator

This block produces the system reset for a microcontroller. Three causes assert reset: the power-on reset of the block itself, a digital indication that the supply is below its threshold (`vcc_ok` low), and expiry of a watchdog. Every cause is stretched: reset stays asserted until a fixed hold-off has elapsed, counted in timebase ticks, after the cause has gone away. All durations are counted in pulses of the `tick` input, so the parameters set how long they are. The defaults assume one tick per 10 ms, which gives a 200 ms hold-off and watchdog periods of 1.4 s, 600 ms and 200 ms.

The watchdog shares its input pin with a serial chip select. Only a high-to-low transition on that pin restarts the count. The pin passes through a two-flop synchronizer, and its falling edge is detected in the block's clock domain. A two-bit select chooses the period, and one code value turns the watchdog off. A flag records whether the most recent reset came from the watchdog. The block also has a permit output that gates the serial command decoder, so that commands are ignored while reset is asserted. The reset pin's polarity is chosen by a parameter. Inside the block, reset is always active-high.

The control is one state machine with three states:
- `ST_SUPPLY_HOLD` waits for `HOLD_TICKS` ticks of an unbroken good supply.
- `ST_RUN` has reset released.
- `ST_WDOG_HOLD` holds reset for `HOLD_TICKS` ticks after a watchdog expiry.

It has these transitions:
- supply-good: `ST_SUPPLY_HOLD` goes to `ST_RUN` once the hold count is reached.
- brownout: any state goes to `ST_SUPPLY_HOLD` whenever `vcc_ok` is low.
- expiry: `ST_RUN` goes to `ST_WDOG_HOLD`.
- wdog-release: `ST_WDOG_HOLD` goes to `ST_RUN` once the hold count is reached.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst_n` is low and afterwards, reset stays asserted and `wd_cause` is 0, until the release condition of R2 is met.
- R2: In `ST_SUPPLY_HOLD`, each clock edge that samples `tick`=1 with `vcc_ok`=1 advances a hold count. Reset releases on the edge that samples the `HOLD_TICKS`-th such tick. Any edge that samples `vcc_ok`=0 restarts the count.
- R3: An edge that samples `vcc_ok`=0 asserts reset from that edge on and clears `wd_cause`. Release then follows R2.
- R4: The watchdog count restarts only on a high-to-low transition of `kick_cs_n`. That restart takes effect on the second edge after the edge that first samples the low level. Holding the pin steadily high or steadily low never restarts the count.
- R5: The watchdog period is set by `wd_sel`: 2'b00 gives `WD_TICKS_LONG` ticks, 2'b01 gives `WD_TICKS_MID` ticks and 2'b10 gives `WD_TICKS_SHORT` ticks. When released reset sees that many ticks with no restart, reset asserts on the edge that samples the last of those ticks.
- R6: `wd_sel`=2'b11 disables the watchdog and keeps its count at zero.
- R7: A watchdog reset is held for `HOLD_TICKS` ticks. After it releases, the watchdog counts a full new period from zero.
- R8: With `ACTIVE_LOW`=1, `rst_out` is low while reset is asserted. With `ACTIVE_LOW`=0, `rst_out` is high while reset is asserted.
- R9: `wd_cause` sets on the edge on which a watchdog expiry asserts reset. It stays set after release and clears only on `rst_n` or when the supply fails (R3).
- R10: `host_access_ok` is 1 exactly while reset is released. Serial commands are to be ignored while it is 0.
- R11: If a kick restart and the final tick of a period land on the same edge, the restart wins. No reset is asserted, and a full new period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Timebase pulse, one clock wide |
| vcc_ok | input | 1 | Supply above threshold (from the comparator) |
| wd_sel | input | 2 | Watchdog period select; 2'b11 turns the watchdog off |
| kick_cs_n | input | 1 | Shared chip-select / watchdog kick pin (asynchronous) |
| rst_out | output | 1 | System reset, polarity set by `ACTIVE_LOW` |
| wd_cause | output | 1 | Last reset came from watchdog expiry |
| host_access_ok | output | 1 | Serial commands may be accepted |

## Verification
Two events can fall on the same clock edge: a kick restart arriving through the synchronizer, and the final tick of a watchdog period. The bench provokes this by dropping `kick_cs_n` exactly two edges before the expiry edge. It then checks that reset stays released and that the next expiry comes one full period later. A supply failure can also fall in the same cycle as an expiry. Random stimulus produces this case, and it is judged against the rule that the supply wins and `wd_cause` stays 0.

// File: rtl/supv_pkg.sv
package supv_pkg;
    typedef enum logic [1:0] {
        ST_SUPPLY_HOLD = 2'd0,
        ST_RUN         = 2'd1,
        ST_WDOG_HOLD   = 2'd2
    } supv_state_e;

    localparam logic [1:0] WD_SEL_LONG  = 2'b00;
    localparam logic [1:0] WD_SEL_MID   = 2'b01;
    localparam logic [1:0] WD_SEL_SHORT = 2'b10;
    localparam logic [1:0] WD_SEL_OFF   = 2'b11;
endpackage

// File: rtl/supv_kick_edge.sv
module supv_kick_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic fall_seen
);
    localparam int NQ = SYNC_STAGES + 1;

    logic [NQ-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[NQ-2:0], pin_in};
        end
    end

    // previous synchronized level high, current synchronized level low
    assign fall_seen = pipe_q[NQ-1] & ~pipe_q[NQ-2];
endmodule

// File: rtl/supv_wd_timer.sv
module supv_wd_timer import supv_pkg::*; #(
    parameter int WD_TICKS_LONG  = 140,
    parameter int WD_TICKS_MID   = 60,
    parameter int WD_TICKS_SHORT = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic       kick_fall,
    input  logic [1:0] sel,
    output logic       expire
);
    localparam int MAX_LM = (WD_TICKS_LONG > WD_TICKS_MID) ? WD_TICKS_LONG : WD_TICKS_MID;
    localparam int MAX_T  = (MAX_LM > WD_TICKS_SHORT) ? MAX_LM : WD_TICKS_SHORT;
    localparam int CW     = $clog2(MAX_T + 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(WD_TICKS_LONG - 1);
    localparam logic [CW-1:0] LAST_MID   = CW'(WD_TICKS_MID - 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(WD_TICKS_SHORT - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_tick;
    logic          active;

    always_comb begin
        unique case (sel)
            WD_SEL_LONG:  last_tick = LAST_LONG;
            WD_SEL_MID:   last_tick = LAST_MID;
            WD_SEL_SHORT: last_tick = LAST_SHORT;
            default:      last_tick = '0;
        endcase
    end

    assign active = run && (sel != WD_SEL_OFF) && !kick_fall;
    assign expire = active && tick && (cnt_q >= last_tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/supv_hold_fsm.sv
module supv_hold_fsm import supv_pkg::*; #(
    parameter int HOLD_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic vcc_ok,
    input  logic wd_expire,
    output logic in_run,
    output logic wd_cause
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

    supv_state_e   state_q, state_d;
    logic [HW-1:0] cnt_q, cnt_d;
    logic          cause_q, cause_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SUPPLY_HOLD;
            cnt_q   <= '0;
            cause_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cause_d = cause_q;
        if (!vcc_ok) begin
            // brownout: any state
            state_d = ST_SUPPLY_HOLD;
            cnt_d   = '0;
            cause_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_SUPPLY_HOLD, ST_WDOG_HOLD: begin
                    if (tick) begin
                        if (cnt_q == HOLD_LAST) begin
                            state_d = ST_RUN;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (wd_expire) begin
                        state_d = ST_WDOG_HOLD;
                        cnt_d   = '0;
                        cause_d = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_SUPPLY_HOLD;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        in_run   = (state_q == ST_RUN);
        wd_cause = cause_q;
    end
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
    parameter int HOLD_TICKS     = 20,
    parameter int WD_TICKS_LONG  = 140,
    parameter int WD_TICKS_MID   = 60,
    parameter int WD_TICKS_SHORT = 20,
    parameter bit ACTIVE_LOW     = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       vcc_ok,
    input  logic [1:0] wd_sel,
    input  logic       kick_cs_n,
    output logic       rst_out,
    output logic       wd_cause,
    output logic       host_access_ok
);
    logic kick_fall;
    logic wd_expire;
    logic in_run;
    logic rst_int;

    supv_kick_edge #(.SYNC_STAGES(2)) u_kick (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (kick_cs_n),
        .fall_seen(kick_fall)
    );

    supv_wd_timer #(
        .WD_TICKS_LONG (WD_TICKS_LONG),
        .WD_TICKS_MID  (WD_TICKS_MID),
        .WD_TICKS_SHORT(WD_TICKS_SHORT)
    ) u_wdt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (in_run),
        .kick_fall(kick_fall),
        .sel      (wd_sel),
        .expire   (wd_expire)
    );

    supv_hold_fsm #(.HOLD_TICKS(HOLD_TICKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .vcc_ok   (vcc_ok),
        .wd_expire(wd_expire),
        .in_run   (in_run),
        .wd_cause (wd_cause)
    );

    assign rst_int        = ~in_run;
    assign host_access_ok = in_run;

    generate
        if (ACTIVE_LOW) begin : g_pol_low
            assign rst_out = ~rst_int;
        end else begin : g_pol_high
            assign rst_out = rst_int;
        end
    endgenerate
endmodule

// File: rtl/supv_reset_checker.sv
module supv_reset_checker #(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic vcc_ok,
    input logic rst_out,
    input logic wd_cause,
    input logic host_access_ok
);
    // R3: a sampled supply failure asserts reset from the next cycle
    p_supply_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> !host_access_ok);

    // R9: a supply failure clears the watchdog cause
    p_cause_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> !wd_cause);

    // R2: release only happens with a good supply sampled
    p_release_needs_supply_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_access_ok) |-> $past(vcc_ok));

    // R5: a new watchdog cause comes together with an asserted reset
    p_expiry_asserts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_cause) |-> !host_access_ok);

    // R8: pin polarity against the access permit
    p_polarity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out == (ACTIVE_LOW ? host_access_ok : !host_access_ok));
endmodule

bind supv_reset_gen supv_reset_checker #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vcc_ok        (vcc_ok),
    .rst_out       (rst_out),
    .wd_cause      (wd_cause),
    .host_access_ok(host_access_ok)
);

// File: tb/sim_supv_reset_gen.sv
`timescale 1ns/1ps
module sim_supv_reset_gen;
    localparam int HOLD  = 20;
    localparam int LONG  = 140;
    localparam int MID   = 60;
    localparam int SHORT = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       vcc_ok = 1'b1;
    logic [1:0] wd_sel = 2'b10;
    logic       kick_cs_n = 1'b1;
    logic       rst_out, wd_cause, host_access_ok;
    logic       rst_out_h, wd_cause_h, host_ok_h;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int  m_mode = 0;     // 0 supply hold, 1 run, 2 watchdog hold
    int  m_hold = 0;
    int  m_wd = 0;
    bit  m_cause = 1'b0;
    bit  k1 = 1'b1, k2 = 1'b1, k3 = 1'b1;

    always #5 clk = ~clk;

    supv_reset_gen #(.HOLD_TICKS(HOLD), .WD_TICKS_LONG(LONG), .WD_TICKS_MID(MID),
                     .WD_TICKS_SHORT(SHORT), .ACTIVE_LOW(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .vcc_ok(vcc_ok), .wd_sel(wd_sel),
        .kick_cs_n(kick_cs_n), .rst_out(rst_out), .wd_cause(wd_cause),
        .host_access_ok(host_access_ok));

    supv_reset_gen #(.HOLD_TICKS(HOLD), .WD_TICKS_LONG(LONG), .WD_TICKS_MID(MID),
                     .WD_TICKS_SHORT(SHORT), .ACTIVE_LOW(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .vcc_ok(vcc_ok), .wd_sel(wd_sel),
        .kick_cs_n(kick_cs_n), .rst_out(rst_out_h), .wd_cause(wd_cause_h),
        .host_access_ok(host_ok_h));

    function automatic int period_of(input logic [1:0] s);
        case (s)
            2'b00:   return LONG;
            2'b01:   return MID;
            2'b10:   return SHORT;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_reset_active();
        return (m_mode != 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    task automatic model_edge();
        bit kf;
        if (!rst_n) begin
            m_mode = 0; m_hold = 0; m_wd = 0; m_cause = 1'b0;
            k1 = 1'b1; k2 = 1'b1; k3 = 1'b1;
            return;
        end
        kf = k3 & ~k2;
        k3 = k2; k2 = k1; k1 = kick_cs_n;
        if (!vcc_ok) begin
            m_mode = 0; m_hold = 0; m_wd = 0; m_cause = 1'b0;
        end else if (m_mode == 1) begin
            if (wd_sel == 2'b11 || kf) begin
                m_wd = 0;
            end else if (tick) begin
                if (m_wd >= period_of(wd_sel) - 1) begin
                    m_mode = 2; m_hold = 0; m_wd = 0; m_cause = 1'b1;
                end else begin
                    m_wd++;
                end
            end
        end else begin
            m_wd = 0;
            if (tick) begin
                if (m_hold == HOLD - 1) begin
                    m_mode = 1; m_hold = 0;
                end else begin
                    m_hold++;
                end
            end
        end
    endtask

    task automatic compare_model();
        bit a;
        string tag;
        a = exp_reset_active();
        tag = (m_mode == 0) ? "R2" : ((m_mode == 2) ? "R7" : "R4");
        chk(rst_out == !a, tag, rst_out, !a);
        chk(host_access_ok == !a, "R10", host_access_ok, !a);
        chk(wd_cause == m_cause, "R9", wd_cause, m_cause);
        chk(rst_out_h == a, "R8", rst_out_h, a);
    endtask

    // one clock edge, model update, then sample mid-cycle
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_model();
        end
    endtask

    task automatic expect_active(input bit a, input string req);
        chk(rst_out == !a, req, rst_out, !a);
    endtask

    initial begin : watchdog_timer
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired before the test finished");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        bit seen;
        int dip;
        void'($urandom(32'd7321));

        // R1: reset state during rst_n
        step(3);
        chk(rst_out == 1'b0, "R1", rst_out, 0);
        chk(host_access_ok == 1'b0, "R10", host_access_ok, 0);
        chk(wd_cause == 1'b0, "R1", wd_cause, 0);
        chk(rst_out_h == 1'b1, "R8", rst_out_h, 1);

        rst_n = 1'b1;
        step(HOLD - 1);
        expect_active(1'b1, "R1");
        step(1);
        expect_active(1'b0, "R2");

        // R5: short period, kick steady high
        step(SHORT - 1);
        expect_active(1'b0, "R5");
        step(1);
        expect_active(1'b1, "R5");
        chk(wd_cause == 1'b1, "R9", wd_cause, 1);

        // R7: hold, then a full new period
        step(HOLD - 1);
        expect_active(1'b1, "R7");
        step(1);
        expect_active(1'b0, "R7");
        chk(wd_cause == 1'b1, "R9", wd_cause, 1);
        step(1);
        expect_active(1'b0, "R7");
        step(SHORT - 2);
        expect_active(1'b0, "R7");
        step(1);
        expect_active(1'b1, "R7");

        // R4: steady low does not restart
        kick_cs_n = 1'b0;
        step(HOLD);
        expect_active(1'b0, "R4");
        step(SHORT - 1);
        expect_active(1'b0, "R4");
        step(1);
        expect_active(1'b1, "R4");
        step(HOLD);
        expect_active(1'b0, "R4");

        // R11: kick restart lands on the expiry edge
        kick_cs_n = 1'b1;
        step(SHORT - 3);
        kick_cs_n = 1'b0;
        step(2);
        expect_active(1'b0, "R11");
        step(1);
        expect_active(1'b0, "R11");
        step(SHORT - 1);
        expect_active(1'b0, "R11");
        step(1);
        expect_active(1'b1, "R11");
        step(HOLD);

        // R6: watchdog off
        wd_sel = 2'b11;
        seen = 1'b0;
        for (int i = 0; i < 3 * LONG; i++) begin
            step(1);
            if (rst_out == 1'b0) seen = 1'b1;
        end
        chk(!seen, "R6", seen, 0);

        // R5: mid period
        wd_sel = 2'b01;
        step(MID - 1);
        expect_active(1'b0, "R5");
        step(1);
        expect_active(1'b1, "R5");
        step(HOLD);

        // R5: long period
        wd_sel = 2'b00;
        step(LONG - 1);
        expect_active(1'b0, "R5");
        step(1);
        expect_active(1'b1, "R5");
        step(HOLD);

        // R4: periodic kicks keep reset released
        wd_sel = 2'b10;
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            kick_cs_n = 1'b1;
            step(SHORT / 4);
            if (rst_out == 1'b0) seen = 1'b1;
            kick_cs_n = 1'b0;
            step(SHORT / 4);
            if (rst_out == 1'b0) seen = 1'b1;
        end
        chk(!seen, "R4", seen, 0);

        // R3: one-cycle supply dip
        vcc_ok = 1'b0;
        step(1);
        expect_active(1'b1, "R3");
        chk(wd_cause == 1'b0, "R3", wd_cause, 0);
        vcc_ok = 1'b1;
        step(HOLD - 1);
        expect_active(1'b1, "R3");
        step(1);
        expect_active(1'b0, "R3");

        // random phase
        dip = 0;
        for (int i = 0; i < 15000; i++) begin
            tick = ($urandom % 3) == 0;
            if (dip > 0) begin
                dip--;
                vcc_ok = 1'b0;
            end else begin
                vcc_ok = 1'b1;
                if (($urandom % 400) == 0) dip = 1 + ($urandom % 5);
            end
            if (($urandom % 40) == 0) kick_cs_n = ~kick_cs_n;
            if (($urandom % 1500) == 0) wd_sel = 2'($urandom % 4);
            step(1);
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule